// File: doc/BRIEF.md
# Polled Interrupt Request and Active Logic

This block is the interrupt section of a single I/O interface. It keeps two state bits: a request bit, meaning the device wants service, and an active bit, meaning the processor has accepted the interrupt and its handler is running. The request can be raised in three ways: by a direct set strobe, by a programmed set strobe, or by an internal abort. The internal abort is either a transfer error or a termination that occurs while clear-interface is enabled.

A processor-side poll asks the device whether it is still interrupting. If the request bit is set, the block answers with a one-cycle acknowledge that carries the configured device number, clears the request and marks the interrupt active. If the request bit is clear, the block answers with a one-cycle cancel instead. The reset-interrupt strobe clears only the active bit. A request that is still pending is therefore withdrawn only through a control word that has its reset bit set, or through a program reset. When it has been withdrawn, the next poll receives a cancel.

Both state bits can be read in the interface status word.

Top module: `irq_poll_unit`

## Requirements
- R1: After reset, `irqReq`, `pollAck` and `pollCancel` are 0, `devNumOut` is 0 and `statusWord` is 0.
- R2: A cycle in which `setIntDirect` or `setIntProg` is high, and nothing clears the request in that cycle, sets the request. `irqReq` is high from the next cycle.
- R3: `resetIntStrobe` clears the active bit only. A pending request stays set, and `irqReq` stays high.
- R4: A rising edge of `pollIn` while the request is set gives `pollAck` high for exactly one cycle, in the next cycle. In that cycle `devNumOut` equals `devNumCfg`, the request is clear and the active bit is set. An active-bit clear in the same cycle as the poll loses to the poll.
- R5: A rising edge of `pollIn` while the request is clear gives `pollCancel` high for exactly one cycle, in the next cycle. `devNumOut` stays 0 and the active bit is unchanged.
- R6: `ctlWrite` together with `ctlIrqReset` clears the request. `ctlWrite` with `ctlIrqReset` low has no effect. Every request clear beats a simultaneous request set.
- R7: A transfer error (`xferError`), or a termination (`termEvent`) while `clearIfEnable` is 1, sets the request only when the stop latch is clear, and then sets the stop latch. A `startIo` clears the stop latch. An event in the same cycle as `startIo` does not fire. A termination while `clearIfEnable` is 0 has no effect.
- R8: `progReset` clears the request. `ifClear` clears the active bit and leaves the request alone.
- R9: Holding `pollIn` high produces only one response. A new response needs `pollIn` to go low and then high again.
- R10: A poll edge and a set strobe in the same cycle are resolved as follows. With the request set, the block acknowledges and the request ends clear. With the request clear, the block cancels and the request ends set.
- R11: `statusWord` has the request in bit 13 and the active bit in bit 12, which are bits 2 and 3 when counted from the MSB. All other bits are 0.
- R12: `pollAck` and `pollCancel` are never high together. `devNumOut` is 0 in every cycle without `pollAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| setIntDirect | input | 1 | Direct set-interrupt strobe |
| setIntProg | input | 1 | Programmed set-interrupt strobe |
| resetIntStrobe | input | 1 | Clears the active bit |
| pollIn | input | 1 | Interrupt poll from the processor |
| ctlWrite | input | 1 | Control word write strobe |
| ctlIrqReset | input | 1 | Reset-interrupt bit of the written control word |
| xferError | input | 1 | Transfer error event |
| termEvent | input | 1 | Termination event |
| clearIfEnable | input | 1 | Termination counts as an abort when 1 |
| startIo | input | 1 | Start of an I/O program; clears the stop latch |
| progReset | input | 1 | Program reset; clears the request |
| ifClear | input | 1 | Interface clear; clears the active bit |
| devNumCfg | input | DEV_W | Device number returned on acknowledge |
| irqReq | output | 1 | Interrupt request line |
| pollAck | output | 1 | One-cycle acknowledge response |
| pollCancel | output | 1 | One-cycle cancel response |
| devNumOut | output | DEV_W | Device number during acknowledge, otherwise 0 |
| statusWord | output | 16 | Status word with the request and active bits |

## Verification
The hardest case to reach is a request that stays pending after a reset-interrupt strobe and is then withdrawn by a control-word reset, so that the next poll cancels rather than acknowledges. The stimulus builds this case directly. It raises a request, takes it through a poll so that the active bit is set, raises a new request, pulses reset-interrupt, then writes a control word with its reset bit set and polls. A second hard case is the stop latch, which has no status bit of its own. The bench observes it through `irqReq`. It fires one abort, clears the request with a program reset, and fires a second abort, which must not set the request. It then pulses start-I/O and fires a third abort, which must set the request. A sweep covers all 16 combinations of prior request, set strobe, control reset and poll edge, each in a single cycle.

// File: rtl/irq_poll_pkg.sv
package irq_poll_pkg;
  // Decisions passed from the control section to the datapath each cycle.
  typedef struct packed {
    logic setReq;   // raise the request
    logic clrReq;   // drop the request (wins over setReq)
    logic grant;    // poll answered with acknowledge
    logic cancel;   // poll answered with cancel
    logic clrAct;   // drop the active bit (loses to grant)
  } irq_strobe_t;

  localparam int STAT_W = 16;
  localparam int REQ_POS = STAT_W - 3;  // bit 2 counted from the MSB
  localparam int ACT_POS = STAT_W - 4;  // bit 3 counted from the MSB
endpackage

// File: rtl/irq_poll_ctl.sv
module irq_poll_ctl
  import irq_poll_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        setIntDirect,
  input  logic        setIntProg,
  input  logic        resetIntStrobe,
  input  logic        pollIn,
  input  logic        ctlWrite,
  input  logic        ctlIrqReset,
  input  logic        xferError,
  input  logic        termEvent,
  input  logic        clearIfEnable,
  input  logic        startIo,
  input  logic        progReset,
  input  logic        ifClear,
  input  logic        reqState,
  output irq_strobe_t strb
);
  logic pollPrev;
  logic stopLatch;
  logic pollEdge;
  logic abortEvent;
  logic abortFire;

  assign pollEdge   = pollIn & ~pollPrev;
  assign abortEvent = xferError | (termEvent & clearIfEnable);
  assign abortFire  = abortEvent & ~stopLatch & ~startIo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollPrev  <= 1'b0;
      stopLatch <= 1'b0;
    end else begin
      pollPrev <= pollIn;
      if (startIo)
        stopLatch <= 1'b0;
      else if (abortEvent)
        stopLatch <= 1'b1;
    end
  end

  always_comb begin
    strb.grant  = pollEdge & reqState;
    strb.cancel = pollEdge & ~reqState;
    strb.setReq = setIntDirect | setIntProg | abortFire;
    strb.clrReq = progReset | (ctlWrite & ctlIrqReset) | strb.grant;
    strb.clrAct = resetIntStrobe | ifClear;
  end
endmodule

// File: rtl/irq_poll_dp.sv
module irq_poll_dp
  import irq_poll_pkg::*;
#(
  parameter int DEV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  irq_strobe_t       strb,
  input  logic [DEV_W-1:0]  devNumCfg,
  output logic              reqState,
  output logic              irqReq,
  output logic              pollAck,
  output logic              pollCancel,
  output logic [DEV_W-1:0]  devNumOut,
  output logic [STAT_W-1:0] statusWord
);
  logic reqQ;
  logic actQ;
  logic ackQ;
  logic cancelQ;
  logic [DEV_W-1:0] devQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ    <= 1'b0;
      actQ    <= 1'b0;
      ackQ    <= 1'b0;
      cancelQ <= 1'b0;
      devQ    <= '0;
    end else begin
      if (strb.clrReq)
        reqQ <= 1'b0;
      else if (strb.setReq)
        reqQ <= 1'b1;
      if (strb.grant)
        actQ <= 1'b1;
      else if (strb.clrAct)
        actQ <= 1'b0;
      ackQ    <= strb.grant;
      cancelQ <= strb.cancel;
      devQ    <= strb.grant ? devNumCfg : '0;
    end
  end

  assign reqState   = reqQ;
  assign irqReq     = reqQ;
  assign pollAck    = ackQ;
  assign pollCancel = cancelQ;
  assign devNumOut  = devQ;

  for (genvar i = 0; i < STAT_W; i++) begin : g_stat
    if (i == REQ_POS) begin : g_req
      assign statusWord[i] = reqQ;
    end else if (i == ACT_POS) begin : g_act
      assign statusWord[i] = actQ;
    end else begin : g_zero
      assign statusWord[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_poll_unit.sv
module irq_poll_unit
  import irq_poll_pkg::*;
#(
  parameter int DEV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             setIntDirect,
  input  logic             setIntProg,
  input  logic             resetIntStrobe,
  input  logic             pollIn,
  input  logic             ctlWrite,
  input  logic             ctlIrqReset,
  input  logic             xferError,
  input  logic             termEvent,
  input  logic             clearIfEnable,
  input  logic             startIo,
  input  logic             progReset,
  input  logic             ifClear,
  input  logic [DEV_W-1:0] devNumCfg,
  output logic             irqReq,
  output logic             pollAck,
  output logic             pollCancel,
  output logic [DEV_W-1:0] devNumOut,
  output logic [15:0]      statusWord
);
  irq_strobe_t strb;
  logic reqState;

  irq_poll_ctl u_ctl (
    .clk(clk), .rstN(rstN),
    .setIntDirect(setIntDirect), .setIntProg(setIntProg),
    .resetIntStrobe(resetIntStrobe), .pollIn(pollIn),
    .ctlWrite(ctlWrite), .ctlIrqReset(ctlIrqReset),
    .xferError(xferError), .termEvent(termEvent),
    .clearIfEnable(clearIfEnable), .startIo(startIo),
    .progReset(progReset), .ifClear(ifClear),
    .reqState(reqState), .strb(strb)
  );

  irq_poll_dp #(.DEV_W(DEV_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .devNumCfg(devNumCfg),
    .reqState(reqState), .irqReq(irqReq), .pollAck(pollAck),
    .pollCancel(pollCancel), .devNumOut(devNumOut),
    .statusWord(statusWord)
  );
endmodule

// File: rtl/irq_poll_chk.sv
module irq_poll_chk #(
  parameter int DEV_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             setIntDirect,
  input logic             setIntProg,
  input logic             resetIntStrobe,
  input logic             pollIn,
  input logic             ctlWrite,
  input logic             ctlIrqReset,
  input logic             progReset,
  input logic             irqReq,
  input logic             pollAck,
  input logic             pollCancel,
  input logic [DEV_W-1:0] devNumOut,
  input logic [15:0]      statusWord
);
  assert_one_response_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(pollAck && pollCancel));

  assert_devnum_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    !pollAck |-> devNumOut == '0);

  assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    pollAck |=> !pollAck);

  assert_cancel_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    pollCancel |=> !pollCancel);

  assert_ack_state_R4: assert property (@(posedge clk) disable iff (!rstN)
    pollAck |-> (!irqReq && statusWord[12]));

  assert_set_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((setIntDirect || setIntProg) && !pollIn && !progReset
     && !(ctlWrite && ctlIrqReset)) |=> irqReq);

  assert_reset_int_R3: assert property (@(posedge clk) disable iff (!rstN)
    (resetIntStrobe && !pollIn) |=> !statusWord[12]);

  assert_prog_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    progReset |=> !irqReq);
endmodule

bind irq_poll_unit irq_poll_chk #(.DEV_W(DEV_W)) u_chk (
  .clk(clk), .rstN(rstN), .setIntDirect(setIntDirect),
  .setIntProg(setIntProg), .resetIntStrobe(resetIntStrobe),
  .pollIn(pollIn), .ctlWrite(ctlWrite), .ctlIrqReset(ctlIrqReset),
  .progReset(progReset), .irqReq(irqReq), .pollAck(pollAck),
  .pollCancel(pollCancel), .devNumOut(devNumOut), .statusWord(statusWord)
);

// File: tb/irq_poll_unit_tb.sv
module irq_poll_unit_tb;
  localparam int DEV_W = 8;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic setIntDirect = 0, setIntProg = 0, resetIntStrobe = 0, pollIn = 0;
  logic ctlWrite = 0, ctlIrqReset = 0, xferError = 0, termEvent = 0;
  logic clearIfEnable = 0, startIo = 0, progReset = 0, ifClear = 0;
  logic [DEV_W-1:0] devNumCfg = 8'h5A;
  logic irqReq, pollAck, pollCancel;
  logic [DEV_W-1:0] devNumOut;
  logic [15:0] statusWord;
  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_poll_unit #(.DEV_W(DEV_W)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    {setIntDirect, setIntProg, resetIntStrobe, pollIn, ctlWrite, ctlIrqReset} = '0;
    {xferError, termEvent, startIo, progReset, ifClear} = '0;
  endtask

  // Clear both state bits and leave pollIn low for one cycle.
  task automatic clean();
    idle(); progReset = 1; ifClear = 1; cyc(); idle(); cyc();
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 irqReq", irqReq, 0);
    chk("R1 ack", pollAck, 0);
    chk("R1 cancel", pollCancel, 0);
    chk("R1 devNumOut", devNumOut, 0);
    chk("R1 status", statusWord, 0);
    rstN = 1; cyc();

    // Sweep: prior request, set strobe, control reset, poll edge (R2 R5 R6 R10 R11 R12)
    for (int k = 0; k < 16; k++) begin
      bit pre, st, cr, pl;
      bit expReq, expAck, expCan;
      {pre, st, cr, pl} = 4'(k);
      clean();
      if (pre) begin setIntDirect = 1; cyc(); idle(); end
      devNumCfg = 8'(8'h11 * k + 3);
      setIntProg = st; ctlWrite = 1; ctlIrqReset = cr; pollIn = pl;
      cyc();
      expAck = pl & pre;
      expCan = pl & ~pre;
      expReq = (cr | expAck) ? 1'b0 : (st ? 1'b1 : pre);
      chk($sformatf("R10 ack k=%0d", k), pollAck, expAck);
      chk($sformatf("R10 cancel k=%0d", k), pollCancel, expCan);
      chk($sformatf("R6 req k=%0d", k), irqReq, expReq);
      chk($sformatf("R12 devnum k=%0d", k), devNumOut, expAck ? devNumCfg : 0);
      chk($sformatf("R11 status k=%0d", k), statusWord,
          (32'(expReq) << 13) | (32'(expAck) << 12));
      idle(); cyc();
      chk($sformatf("R9 no repeat k=%0d", k), pollAck | pollCancel, 0);
    end

    // R9: poll held high answers once
    clean(); setIntDirect = 1; cyc(); idle();
    pollIn = 1; cyc();
    chk("R4 ack", pollAck, 1);
    setIntDirect = 1; cyc(); setIntDirect = 0; cyc();
    chk("R9 held poll no ack", pollAck, 0);
    chk("R9 req pending", irqReq, 1);
    pollIn = 0; cyc(); pollIn = 1; cyc();
    chk("R9 second edge ack", pollAck, 1);
    idle(); cyc();

    // R3: reset-int keeps request; then withdrawn by control reset -> cancel (R6)
    setIntDirect = 1; cyc(); idle();
    resetIntStrobe = 1; cyc(); idle();
    chk("R3 active cleared", statusWord[12], 0);
    chk("R3 request kept", irqReq, 1);
    ctlWrite = 1; cyc(); idle();
    chk("R6 write without bit", irqReq, 1);
    ctlWrite = 1; ctlIrqReset = 1; cyc(); idle();
    chk("R6 request withdrawn", irqReq, 0);
    pollIn = 1; cyc();
    chk("R5 cancel", pollCancel, 1);
    chk("R5 devnum zero", devNumOut, 0);
    idle(); cyc();

    // R4: grant beats simultaneous active clear
    clean(); setIntDirect = 1; cyc(); idle();
    pollIn = 1; ifClear = 1; cyc(); idle();
    chk("R4 active set", statusWord[12], 1);
    // R8: ifClear clears active, leaves request
    setIntProg = 1; cyc(); idle();
    ifClear = 1; cyc(); idle();
    chk("R8 ifClear active", statusWord[12], 0);
    chk("R8 ifClear keeps req", irqReq, 1);
    progReset = 1; cyc(); idle();
    chk("R8 progReset req", irqReq, 0);

    // R7: abort once until startIo
    startIo = 1; cyc(); idle();
    xferError = 1; cyc(); idle();
    chk("R7 first abort", irqReq, 1);
    progReset = 1; cyc(); idle();
    xferError = 1; cyc(); idle();
    chk("R7 latched abort", irqReq, 0);
    termEvent = 1; clearIfEnable = 1; cyc(); idle();
    chk("R7 latched term", irqReq, 0);
    startIo = 1; cyc(); idle();
    termEvent = 1; clearIfEnable = 0; cyc(); idle();
    chk("R7 term without enable", irqReq, 0);
    termEvent = 1; clearIfEnable = 1; cyc(); idle();
    chk("R7 term fires", irqReq, 1);
    progReset = 1; cyc(); idle();
    startIo = 1; xferError = 1; cyc(); idle();
    chk("R7 start suppresses", irqReq, 0);
    xferError = 1; cyc(); idle();
    chk("R7 fires after start", irqReq, 1);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule